// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the memory address that a load, store or jump will use, from the addressing mode carried by the instruction. It takes a 3-bit mode code, the current value of the selected base register, the address or offset field of the instruction and the address of the instruction that follows the current one. It returns the effective address. It also returns an updated base register value and an enable that tells the register file to write that value back.

Six modes are supported:

- absolute addressing from the instruction field;
- register indirect;
- register plus a signed offset;
- offset from the next instruction's address;
- post-increment of the base;
- pre-decrement of the base.

The step for the two auto-update modes is one or two bytes, picked per request. Offsets are 8-bit two's complement values, sign-extended to the address width, and all address arithmetic wraps around the address space.

The arithmetic is a single combinational stage. Its results are registered, so the address and write-back appear one cycle after a request strobe.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, and after it, until the first strobe, `out_valid`, `base_we` and `ea` are all 0.
- R2: Mode code 0 (absolute) gives `ea` equal to the full `addr_field`, `base_new` equal to `base_val` and `base_we` 0.
- R3: Mode code 1 (register indirect) gives `ea` equal to `base_val` and `base_we` 0.
- R4: Mode code 2 (register plus offset) gives `ea` = `base_val` + sign-extended `addr_field[7:0]`, and `base_we` is 0. Bits 15:8 of `addr_field` have no effect in this mode.
- R5: Mode code 3 (next-instruction relative) gives `ea` = `next_pc` + sign-extended `addr_field[7:0]`, and `base_we` is 0.
- R6: Mode code 4 (post-increment) gives `ea` equal to the old `base_val`, gives `base_new` = `base_val` + step, and sets `base_we` to 1.
- R7: Mode code 5 (pre-decrement) gives `ea` and `base_new` both equal to `base_val` − step, and sets `base_we` to 1.
- R8: The step is 1 when `step_two` is 0 and 2 when `step_two` is 1.
- R9: All sums and differences wrap modulo 2^16. Offset byte 0x80 means −128 and 0x7F means +127.
- R10: The results of a request sampled with `req_valid` high appear on the next cycle, together with a one-cycle `out_valid` pulse. In a cycle after a clock edge with no strobe, `out_valid` and `base_we` are 0 and `ea` holds its previous value.
- R11: Reserved mode codes 6 and 7 behave like mode 0: `ea` equals `addr_field` and `base_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| base_val | input | 16 | Current base register value |
| addr_field | input | 16 | Absolute address, or offset in bits 7:0 |
| next_pc | input | 16 | Address of the following instruction |
| step_two | input | 1 | Auto-update step: 0 gives 1, 1 gives 2 |
| out_valid | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| base_new | output | 16 | Updated base register value |
| base_we | output | 1 | Base write-back enable |

## Verification
Every mode is driven with a field whose upper byte is non-zero. This separates the modes that use the whole field from those that must look only at the offset byte. Offsets of +127, −128 and small negative values, near the top and bottom of the address space, tell correct sign extension and wrap-around apart from zero extension. Both auto-update modes are run with both step sizes and with bases at 0x0000 and 0xFFFF, which distinguishes post-use from pre-use update and step 1 from step 2. Back-to-back strobes followed by idle cycles separate the one-cycle pulse and the holding of `ea` from outputs that stay asserted.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW    = 16,
  parameter int OFS_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] addr_field,
  input  logic [AW-1:0] next_pc,
  input  logic          step_two,
  output logic          out_valid,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] base_new,
  output logic          base_we
);

  localparam int EXT = AW - OFS_W;
  localparam logic [2:0] M_ABS  = 3'd0;
  localparam logic [2:0] M_IND  = 3'd1;
  localparam logic [2:0] M_REL  = 3'd2;
  localparam logic [2:0] M_PCR  = 3'd3;
  localparam logic [2:0] M_INC  = 3'd4;
  localparam logic [2:0] M_DEC  = 3'd5;

  logic [AW-1:0] ofs, step, inc_v, dec_v;
  logic [AW-1:0] ea_c, bn_c;
  logic          we_c;

  assign ofs   = {{EXT{addr_field[OFS_W-1]}}, addr_field[OFS_W-1:0]};
  assign step  = step_two ? AW'(2) : AW'(1);
  assign inc_v = base_val + step;
  assign dec_v = base_val - step;

  always_comb begin
    ea_c = addr_field;
    bn_c = base_val;
    we_c = 1'b0;
    case (mode)
      M_ABS: ea_c = addr_field;
      M_IND: ea_c = base_val;
      M_REL: ea_c = base_val + ofs;
      M_PCR: ea_c = next_pc + ofs;
      M_INC: begin
        ea_c = base_val;
        bn_c = inc_v;
        we_c = 1'b1;
      end
      M_DEC: begin
        ea_c = dec_v;
        bn_c = dec_v;
        we_c = 1'b1;
      end
      default: ea_c = addr_field;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      base_we   <= 1'b0;
      ea        <= '0;
      base_new  <= '0;
    end else begin
      out_valid <= req_valid;
      base_we   <= req_valid & we_c;
      if (req_valid) begin
        ea       <= ea_c;
        base_new <= bn_c;
      end
    end
  end

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    mode,
  input logic [AW-1:0] base_val,
  input logic [AW-1:0] addr_field,
  input logic [AW-1:0] next_pc,
  input logic          step_two,
  input logic          out_valid,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] base_new,
  input logic          base_we
);

  p_we_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> out_valid);

  p_pulse_follows_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_valid));

  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> $stable(ea));

  p_abs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) == 3'd0) |-> (ea == $past(addr_field) && !base_we));

  p_indirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) == 3'd1) |-> (ea == $past(base_val) && !base_we));

  p_postinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) == 3'd4) |->
      (ea == $past(base_val) && base_we &&
       base_new == AW'($past(base_val) + ($past(step_two) ? AW'(2) : AW'(1)))));

  p_predec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) == 3'd5) |->
      (ea == base_new && base_we &&
       base_new == AW'($past(base_val) - ($past(step_two) ? AW'(2) : AW'(1)))));

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) > 3'd5) |-> (ea == $past(addr_field) && !base_we));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] base_val = '0, addr_field = '0, next_pc = '0;
  logic        step_two = 1'b0;
  logic        out_valid, base_we;
  logic [15:0] ea, base_new;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] q_ea[$];
  logic [15:0] q_bn[$];
  logic        q_we[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .base_val(base_val), .addr_field(addr_field), .next_pc(next_pc),
    .step_two(step_two), .out_valid(out_valid), .ea(ea),
    .base_new(base_new), .base_we(base_we)
  );

  function automatic logic [15:0] sx(input logic [15:0] f);
    return {{8{f[7]}}, f[7:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [15:0] b, input logic [15:0] f,
                       input logic [15:0] pc, input logic s2, input string tag);
    logic [15:0] st, e, bn;
    logic w;
    @(negedge clk);
    req_valid = 1'b1; mode = m; base_val = b; addr_field = f; next_pc = pc; step_two = s2;
    st = s2 ? 16'd2 : 16'd1;
    e = f; bn = b; w = 1'b0;
    case (m)
      3'd1: e = b;
      3'd2: e = b + sx(f);
      3'd3: e = pc + sx(f);
      3'd4: begin e = b; bn = b + st; w = 1'b1; end
      3'd5: begin e = b - st; bn = b - st; w = 1'b1; end
      default: e = f;
    endcase
    q_ea.push_back(e); q_bn.push_back(bn); q_we.push_back(w); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_ea.size() == 0) begin
        check("R10 unexpected out_valid", 32'(out_valid), 32'd0);
      end else begin
        string t;
        logic [15:0] e, bn;
        logic w;
        t = q_tag.pop_front(); e = q_ea.pop_front(); bn = q_bn.pop_front(); w = q_we.pop_front();
        check({t, " ea"}, 32'(ea), 32'(e));
        check({t, " base_new"}, 32'(base_new), 32'(bn));
        check({t, " base_we"}, 32'(base_we), 32'(w));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", 32'(out_valid), 32'd0);
    check("R1 ea in reset", 32'(ea), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 base_we after reset", 32'(base_we), 32'd0);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);

    drive(3'd0, 16'h1234, 16'hBEEF, 16'h0100, 1'b0, "R2 absolute");
    drive(3'd1, 16'h4321, 16'hBEEF, 16'h0100, 1'b1, "R3 indirect");
    drive(3'd2, 16'h1000, 16'hAB05, 16'h0100, 1'b0, "R4 rel upper ignored");
    drive(3'd2, 16'h1000, 16'h0080, 16'h0100, 1'b0, "R9 rel -128");
    drive(3'd2, 16'hFFF0, 16'h7720, 16'h0100, 1'b0, "R9 rel wrap");
    drive(3'd2, 16'h0010, 16'h007F, 16'h0100, 1'b0, "R9 rel +127");
    drive(3'd3, 16'h5555, 16'h12FE, 16'h2002, 1'b0, "R5 pcrel -2");
    drive(3'd3, 16'h5555, 16'h0010, 16'hFFFC, 1'b0, "R5 pcrel wrap");
    drive(3'd4, 16'h0200, 16'h9999, 16'h0000, 1'b0, "R6 postinc step1 R8");
    drive(3'd4, 16'hFFFF, 16'h9999, 16'h0000, 1'b1, "R6 postinc step2 wrap R8");
    drive(3'd5, 16'h0200, 16'h9999, 16'h0000, 1'b1, "R7 predec step2 R8");
    drive(3'd5, 16'h0000, 16'h9999, 16'h0000, 1'b0, "R7 predec step1 wrap");
    drive(3'd6, 16'h0300, 16'hC0DE, 16'h0000, 1'b1, "R11 reserved 6");
    drive(3'd7, 16'h0300, 16'hFACE, 16'h0000, 1'b0, "R11 reserved 7");

    @(negedge clk);
    req_valid = 1'b0; mode = 3'd4; base_val = 16'h7777;
    @(negedge clk);
    held = ea;
    @(negedge clk);
    check("R10 out_valid idle", 32'(out_valid), 32'd0);
    check("R10 base_we idle", 32'(base_we), 32'd0);
    check("R10 ea held", 32'(ea), 32'(held));
    check("R10 ea held value", 32'(ea), 32'hFACE);
    check("R10 queue drained", 32'(q_ea.size()), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule